// File: doc/BRIEF.md
# One-Time-Programmable Array Controller

This block gives a processor register access to a small one-time-programmable (OTP) array. Software writes a command code, a row address and one or two words of program data into registers. It then raises a start bit and polls a status register. The status register has a completion flag and a flag that reports program permission. When a read completes, the row's words are copied into read-data registers. A program operation can never clear a stored bit. It only sets bits, and its busy time grows with the number of ones in the data.

Programming is locked after reset. Software unlocks it by issuing four separately started unlock commands, each carrying a specific key word. A lock command closes it again. A mode bit must be set before any command is accepted. The `ROW_WORDS` parameter selects rows of one or two 32-bit words. The array depth and the busy-time constants are also parameters, so that simulation stays short.

Top module: `otp_ctrl_top`

## Requirements
- R1: After reset, every readable register returns zero, including status. Programming is locked and every array row holds zero.
- R2: Registers decode at these byte offsets: mode 0x00, command 0x04, start 0x08, status 0x0C, row address 0x28, program data word 0 at 0x2C and word 1 at 0x64, read data word 0 at 0x10 and word 1 at 0x5C. The command register keeps only bits 5:0 and the address register keeps only bits 15:0. Writes to status change nothing.
- R3: Mode bit 0 enables command execution. While it is 0, raising start starts nothing and status stays unchanged.
- R4: A command is accepted only when start bit 0 goes from 0 to 1 and the engine is idle. Acceptance clears status bits 1 (done) and 2 (ok). Done then stays low while busy and stays high after completion until the next accepted start. Rewriting 1 to an already-set start bit has no effect.
- R5: Command code 0x00 (read) completes one cycle after acceptance. It loads the addressed row's word 0 into offset 0x10 and word 1 into offset 0x5C.
- R6: Command code 0x02 (unlock) carries its key in program data word 0. Keys 0xF, 0x4, 0x8, 0xD, issued in that order as four separately started commands, unlock programming. Only the fourth completion sets ok. The earlier three finish with ok low.
- R7: An unlock command whose key is not the one expected at the current step restarts the key sequence from its first step. The locked state and the low ok flag remain.
- R8: Command code 0x0A (program) issued while locked completes with done set and ok low. It leaves the array unchanged.
- R9: A program command issued while unlocked ORs the program data into the addressed row and completes with ok set. A bit that is already 1 stays 1.
- R10: A program command completes 1 + BASE_CYC + BIT_CYC × (number of ones across the row's program words) cycles after acceptance. Every other command completes in 1 cycle.
- R11: Command code 0x03 (lock) relocks programming and restarts the key sequence. It completes with ok set. Later program commands change nothing until a full unlock sequence is issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr (combinational) |

## Verification
The bench targets the unlock sequence. A key out of order must restart it, so a design that advances on any unlock command, or that resumes mid-sequence, would unlock early and would then let a later program write land in the array. Locked programming and programming after a relock are both checked by reading the row back. A design that overwrites rows instead of ORing would lose bits that were set before. The bench measures busy time against the ones count for an all-ones row, a sparse row and an all-zero row. It also rewrites start while start is already set, and a design that triggers on level rather than on the rising edge would drop done at that point.

// File: rtl/otp_pkg.sv
package otp_pkg;

    // Register byte offsets (software decodes these)
    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_CMD   = 8'h04;
    localparam logic [7:0] OFS_START = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_RD0   = 8'h10;
    localparam logic [7:0] OFS_ADDR  = 8'h28;
    localparam logic [7:0] OFS_WD0   = 8'h2C;
    localparam logic [7:0] OFS_RD1   = 8'h5C;
    localparam logic [7:0] OFS_WD1   = 8'h64;

    // Command codes
    localparam logic [5:0] CMD_READ   = 6'h00;
    localparam logic [5:0] CMD_UNLOCK = 6'h02;
    localparam logic [5:0] CMD_LOCK   = 6'h03;
    localparam logic [5:0] CMD_PROG   = 6'h0A;

    localparam int STAT_DONE_BIT = 1;
    localparam int STAT_OK_BIT   = 2;

    typedef enum logic {ST_IDLE, ST_BUSY} otp_state_e;

    typedef struct packed {
        logic [5:0]  op;
        logic [63:0] data;
    } otp_req_t;

    function automatic int ones64(input logic [63:0] v);
        int c;
        c = 0;
        for (int i = 0; i < 64; i++) c = c + int'(v[i]);
        return c;
    endfunction

    function automatic logic [31:0] unlock_key(input logic [1:0] step);
        case (step)
            2'd0:    return 32'h0000_000F;
            2'd1:    return 32'h0000_0004;
            2'd2:    return 32'h0000_0008;
            default: return 32'h0000_000D;
        endcase
    endfunction

    function automatic logic [7:0] wr_ofs(input int w);
        return (w == 0) ? OFS_WD0 : OFS_WD1;
    endfunction

    function automatic logic [7:0] rd_ofs(input int w);
        return (w == 0) ? OFS_RD0 : OFS_RD1;
    endfunction

endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
    import otp_pkg::*;
#(
    parameter int ROW_WORDS = 2,
    parameter int ROW_AW    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    input  logic [63:0]       rd_row,
    input  logic              rd_load,
    input  logic              done,
    input  logic              ok,
    output logic              mode_en,
    output logic              start_req,
    output otp_req_t          req,
    output logic [ROW_AW-1:0] row_idx,
    output logic [31:0]       rdata
);
    logic        mode_q;
    logic [5:0]  cmd_q;
    logic        start_q;
    logic [15:0] addr_q;
    logic [31:0] wd_q [ROW_WORDS];
    logic [31:0] rd_q [ROW_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            cmd_q   <= '0;
            start_q <= 1'b0;
            addr_q  <= '0;
        end else if (we) begin
            case (addr)
                OFS_MODE:  mode_q  <= wdata[0];
                OFS_CMD:   cmd_q   <= wdata[5:0];
                OFS_START: start_q <= wdata[0];
                OFS_ADDR:  addr_q  <= wdata[15:0];
                default: ;
            endcase
        end
    end

    for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                wd_q[w] <= '0;
                rd_q[w] <= '0;
            end else begin
                if (we && addr == wr_ofs(w)) wd_q[w] <= wdata;
                if (rd_load) rd_q[w] <= rd_row[32*w +: 32];
            end
        end
    end

    assign mode_en   = mode_q;
    assign start_req = we && (addr == OFS_START) && wdata[0] && !start_q;
    assign row_idx   = addr_q[ROW_AW-1:0];

    always_comb begin
        req.op   = cmd_q;
        req.data = '0;
        for (int w = 0; w < ROW_WORDS; w++) req.data[32*w +: 32] = wd_q[w];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MODE:  rdata = {31'b0, mode_q};
            OFS_CMD:   rdata = {26'b0, cmd_q};
            OFS_START: rdata = {31'b0, start_q};
            OFS_STAT:  begin
                rdata[STAT_DONE_BIT] = done;
                rdata[STAT_OK_BIT]   = ok;
            end
            OFS_ADDR:  rdata = {16'b0, addr_q};
            default: ;
        endcase
        for (int w = 0; w < ROW_WORDS; w++) begin
            if (addr == rd_ofs(w)) rdata = rd_q[w];
            if (addr == wr_ofs(w)) rdata = wd_q[w];
        end
    end
endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int ROW_AW   = 4,
    parameter int ROW_BITS = 64,
    parameter int BASE_CYC = 3,
    parameter int BIT_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    input  logic                mode_en,
    input  otp_req_t            req,
    input  logic [ROW_AW-1:0]   row_idx,
    output logic                go,
    output logic                busy,
    output logic                done,
    output logic                ok,
    output logic                unlocked,
    output logic                arr_we,
    output logic [ROW_AW-1:0]   arr_idx,
    output logic [ROW_BITS-1:0] arr_wdata,
    output logic                rd_load
);
    localparam int MAX_COST = BASE_CYC + BIT_CYC * ROW_BITS;
    localparam int CNT_W    = $clog2(MAX_COST + 1);

    otp_state_e          state_q;
    logic [5:0]          op_q;
    logic [ROW_BITS-1:0] data_q;
    logic [ROW_AW-1:0]   idx_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cost;
    logic [1:0]          step_q;
    logic                unlocked_q;
    logic                done_q;
    logic                ok_q;
    logic                finish;

    always_comb begin
        int tot;
        tot  = BASE_CYC + BIT_CYC * ones64(req.data);
        cost = (req.op == CMD_PROG) ? CNT_W'(tot) : '0;
    end

    assign go     = start_req && mode_en && (state_q == ST_IDLE);
    assign finish = (state_q == ST_BUSY) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_q       <= '0;
            data_q     <= '0;
            idx_q      <= '0;
            cnt_q      <= '0;
            step_q     <= '0;
            unlocked_q <= 1'b0;
            done_q     <= 1'b0;
            ok_q       <= 1'b0;
        end else if (go) begin
            state_q <= ST_BUSY;
            op_q    <= req.op;
            data_q  <= req.data[ROW_BITS-1:0];
            idx_q   <= row_idx;
            cnt_q   <= cost;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
        end else if (state_q == ST_BUSY) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                case (op_q)
                    CMD_UNLOCK: begin
                        if (unlocked_q) begin
                            ok_q <= 1'b1;
                        end else if (data_q[31:0] == unlock_key(step_q)) begin
                            if (step_q == 2'd3) begin
                                unlocked_q <= 1'b1;
                                ok_q       <= 1'b1;
                                step_q     <= '0;
                            end else begin
                                step_q <= step_q + 2'd1;
                            end
                        end else begin
                            step_q <= '0;
                        end
                    end
                    CMD_LOCK: begin
                        unlocked_q <= 1'b0;
                        step_q     <= '0;
                        ok_q       <= 1'b1;
                    end
                    CMD_PROG: ok_q <= unlocked_q;
                    default: ;
                endcase
            end
        end
    end

    assign busy      = (state_q == ST_BUSY);
    assign done      = done_q;
    assign ok        = ok_q;
    assign unlocked  = unlocked_q;
    assign arr_we    = finish && (op_q == CMD_PROG) && unlocked_q;
    assign rd_load   = finish && (op_q == CMD_READ);
    assign arr_idx   = idx_q;
    assign arr_wdata = data_q;
endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int ROW_AW   = 4,
    parameter int ROW_BITS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ROW_AW-1:0]   idx,
    input  logic [ROW_BITS-1:0] wdata,
    output logic [ROW_BITS-1:0] rdata
);
    localparam int ROWS = 1 << ROW_AW;

    logic [ROW_BITS-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (we) begin
            mem_q[idx] <= mem_q[idx] | wdata;
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/otp_ctrl_top.sv
module otp_ctrl_top
    import otp_pkg::*;
#(
    parameter int ROW_WORDS = 2,
    parameter int ROW_AW    = 4,
    parameter int BASE_CYC  = 3,
    parameter int BIT_CYC   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int ROW_BITS = 32 * ROW_WORDS;

    logic                mode_en;
    logic                start_req;
    otp_req_t            req;
    logic [ROW_AW-1:0]   row_idx;
    logic                go;
    logic                busy;
    logic                done;
    logic                ok;
    logic                unlocked;
    logic                arr_we;
    logic [ROW_AW-1:0]   arr_idx;
    logic [ROW_BITS-1:0] arr_wdata;
    logic [ROW_BITS-1:0] arr_row;
    logic                rd_load;
    logic [63:0]         rd_row;

    assign rd_row = 64'(arr_row);

    otp_regfile #(.ROW_WORDS(ROW_WORDS), .ROW_AW(ROW_AW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rd_row(rd_row), .rd_load(rd_load), .done(done), .ok(ok),
        .mode_en(mode_en), .start_req(start_req), .req(req),
        .row_idx(row_idx), .rdata(reg_rdata)
    );

    otp_seq #(.ROW_AW(ROW_AW), .ROW_BITS(ROW_BITS),
              .BASE_CYC(BASE_CYC), .BIT_CYC(BIT_CYC)) u_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .mode_en(mode_en),
        .req(req), .row_idx(row_idx), .go(go), .busy(busy), .done(done),
        .ok(ok), .unlocked(unlocked), .arr_we(arr_we), .arr_idx(arr_idx),
        .arr_wdata(arr_wdata), .rd_load(rd_load)
    );

    otp_array #(.ROW_AW(ROW_AW), .ROW_BITS(ROW_BITS)) u_arr (
        .clk(clk), .rst(rst), .we(arr_we), .idx(arr_idx),
        .wdata(arr_wdata), .rdata(arr_row)
    );
endmodule

// File: rtl/otp_ctrl_chk.sv
module otp_ctrl_chk #(
    parameter int ROW_BITS = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                mode_en,
    input logic                go,
    input logic                busy,
    input logic                done,
    input logic                ok,
    input logic                unlocked,
    input logic                arr_we,
    input logic [ROW_BITS-1:0] arr_row
);
    assert_mode_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !mode_en |-> !go);

    assert_done_clear_R4: assert property (@(posedge clk) disable iff (rst)
        go |=> !done);

    assert_busy_no_done_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_ok_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        ok |-> done);

    assert_locked_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> unlocked);

    assert_bits_only_set_R9: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> ((arr_row & $past(arr_row)) == $past(arr_row)));
endmodule

bind otp_ctrl_top otp_ctrl_chk #(.ROW_BITS(ROW_BITS)) u_chk (
    .clk(clk), .rst(rst), .mode_en(mode_en), .go(go), .busy(busy),
    .done(done), .ok(ok), .unlocked(unlocked), .arr_we(arr_we),
    .arr_row(arr_row)
);

// File: tb/otp_ctrl_top_bench.sv
module otp_ctrl_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 3;
    localparam int PERBIT = 2;

    localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08,
                           A_STAT = 8'h0C, A_RD0 = 8'h10, A_ADDR = 8'h28,
                           A_WD0 = 8'h2C, A_RD1 = 8'h5C, A_WD1 = 8'h64;
    localparam logic [31:0] C_READ = 32'h00, C_UNLK = 32'h02,
                            C_LOCK = 32'h03, C_PROG = 32'h0A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    otp_ctrl_top #(.ROW_WORDS(2), .ROW_AW(4), .BASE_CYC(BASE), .BIT_CYC(PERBIT))
        u_otp_ctrl_top (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
                        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(output int n);
        logic [31:0] s;
        n = 1;
        rd(A_STAT, s);
        while (!s[1] && n < 2000) begin
            @(negedge clk);
            n++;
            rd(A_STAT, s);
        end
    endtask

    task automatic run_cmd(input logic [31:0] op, input logic [31:0] row,
                           input logic [31:0] w0, input logic [31:0] w1,
                           output int n, output logic [31:0] st);
        wr(A_CMD, op); wr(A_ADDR, row); wr(A_WD0, w0); wr(A_WD1, w1);
        wr(A_START, 32'h1);
        wait_done(n);
        rd(A_STAT, st);
        wr(A_START, 32'h0);
    endtask

    task automatic read_row(input logic [31:0] row, output logic [31:0] d0,
                            output logic [31:0] d1);
        int n;
        logic [31:0] st;
        run_cmd(C_READ, row, 32'h0, 32'h0, n, st);
        rd(A_RD0, d0);
        rd(A_RD1, d1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_STAT, d);  chk("R1 status after reset", d, 32'h0);
        rd(A_MODE, d);  chk("R1 mode after reset", d, 32'h0);
        rd(A_CMD, d);   chk("R1 command after reset", d, 32'h0);
        rd(A_RD1, d);   chk("R1 read word1 after reset", d, 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        wr(A_CMD, 32'hFFFF_FFCA);
        rd(A_CMD, d);   chk("R2 command field 6 bits", d, 32'h0A);
        wr(A_ADDR, 32'h5A5A_9876);
        rd(A_ADDR, d);  chk("R2 address field 16 bits", d, 32'h9876);
        wr(A_WD1, 32'hCAFE_0001);
        rd(A_WD1, d);   chk("R2 word1 program data at 0x64", d, 32'hCAFE_0001);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d);  chk("R2 status not writable", d, 32'h0);
    endtask

    task automatic t_mode_gate;
        logic [31:0] d;
        wr(A_CMD, C_READ);
        wr(A_START, 32'h1);
        repeat (5) @(negedge clk);
        rd(A_STAT, d);  chk("R3 start ignored with mode clear", d, 32'h0);
        wr(A_START, 32'h0);
        wr(A_MODE, 32'h1);
        rd(A_MODE, d);  chk("R3 mode bit set", d, 32'h1);
    endtask

    task automatic t_read_blank;
        int n;
        logic [31:0] st, d;
        run_cmd(C_READ, 32'h3, 32'h0, 32'h0, n, st);
        chk("R5 read done, ok low", st, 32'h2);
        chk("R10 read completes in 1 cycle", 32'(n), 32'd2);
        rd(A_RD0, d);  chk("R5 blank row word0", d, 32'h0);
    endtask

    task automatic t_locked_prog;
        int n;
        logic [31:0] st, d0, d1;
        run_cmd(C_PROG, 32'h2, 32'h1234, 32'h55, n, st);
        chk("R8 locked program done, ok low", st, 32'h2);
        read_row(32'h2, d0, d1);
        chk("R8 locked program word0 untouched", d0, 32'h0);
        chk("R8 locked program word1 untouched", d1, 32'h0);
    endtask

    task automatic t_bad_unlock;
        int n;
        logic [31:0] st, d0, d1;
        run_cmd(C_UNLK, 0, 32'hF, 0, n, st);
        run_cmd(C_UNLK, 0, 32'h4, 0, n, st);
        run_cmd(C_UNLK, 0, 32'hD, 0, n, st);
        chk("R7 wrong key ok low", st, 32'h2);
        run_cmd(C_UNLK, 0, 32'h8, 0, n, st);
        run_cmd(C_UNLK, 0, 32'hD, 0, n, st);
        chk("R7 resumed tail does not unlock", st, 32'h2);
        run_cmd(C_PROG, 32'h2, 32'hFF, 32'hFF, n, st);
        read_row(32'h2, d0, d1);
        chk("R7 still locked, row unchanged", d0, 32'h0);
    endtask

    task automatic t_unlock;
        int n;
        logic [31:0] st;
        run_cmd(C_UNLK, 0, 32'hF, 0, n, st);
        chk("R6 step1 ok low", st, 32'h2);
        run_cmd(C_UNLK, 0, 32'h4, 0, n, st);
        run_cmd(C_UNLK, 0, 32'h8, 0, n, st);
        chk("R6 step3 ok low", st, 32'h2);
        run_cmd(C_UNLK, 0, 32'hD, 0, n, st);
        chk("R6 fourth key sets ok", st, 32'h6);
    endtask

    task automatic t_prog_or;
        int n;
        logic [31:0] st, d0, d1;
        run_cmd(C_PROG, 32'h5, 32'h0000_00F0, 32'h1, n, st);
        chk("R9 program ok", st, 32'h6);
        chk("R10 busy for 5 ones", 32'(n), 32'(2 + BASE + PERBIT * 5));
        run_cmd(C_PROG, 32'h5, 32'h0F00_0000, 32'h2, n, st);
        chk("R10 busy for 5 ones again", 32'(n), 32'(2 + BASE + PERBIT * 5));
        read_row(32'h5, d0, d1);
        chk("R9 word0 OR", d0, 32'h0F00_00F0);
        chk("R9 word1 OR", d1, 32'h3);
        run_cmd(C_PROG, 32'h5, 32'h0, 32'h0, n, st);
        chk("R10 busy with zero data", 32'(n), 32'(2 + BASE));
        read_row(32'h5, d0, d1);
        chk("R9 zero data clears nothing", d0, 32'h0F00_00F0);
    endtask

    task automatic t_timing;
        int n;
        logic [31:0] st, d0, d1;
        run_cmd(C_PROG, 32'h9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, n, st);
        chk("R10 all-ones row busy", 32'(n), 32'(2 + BASE + PERBIT * 64));
        read_row(32'h9, d0, d1);
        chk("R9 all-ones word1", d1, 32'hFFFF_FFFF);
        run_cmd(C_PROG, 32'hA, 32'h8000_0001, 32'h0, n, st);
        chk("R10 two-bit word busy", 32'(n), 32'(2 + BASE + PERBIT * 2));
    endtask

    task automatic t_start_edge;
        logic [31:0] d;
        wr(A_CMD, C_READ); wr(A_ADDR, 32'h5);
        wr(A_START, 32'h1);
        rd(A_STAT, d);  chk("R4 done cleared on accept", d, 32'h0);
        @(negedge clk);
        rd(A_STAT, d);  chk("R4 done after read", d, 32'h2);
        rd(A_RD0, d);   chk("R5 read word0 at 0x10", d, 32'h0F00_00F0);
        wr(A_START, 32'h1);
        rd(A_STAT, d);  chk("R4 start held high does not restart", d, 32'h2);
        repeat (3) @(negedge clk);
        rd(A_STAT, d);  chk("R4 done held", d, 32'h2);
        wr(A_START, 32'h0);
    endtask

    task automatic t_lock;
        int n;
        logic [31:0] st, d0, d1;
        run_cmd(C_LOCK, 0, 0, 0, n, st);
        chk("R11 lock reports ok", st, 32'h6);
        run_cmd(C_PROG, 32'hB, 32'hFF, 32'h0, n, st);
        chk("R11 program after lock ok low", st, 32'h2);
        read_row(32'hB, d0, d1);
        chk("R11 row untouched after lock", d0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_mode_gate();
        t_read_blank();
        t_locked_prog();
        t_bad_unlock();
        t_unlock();
        t_prog_or();
        t_timing();
        t_start_edge();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule